// File: doc/BRIEF.md
# Carry-Less Multiplier with Low, Reversed and High Views

This block multiplies two XLEN-bit operands in GF(2) polynomial arithmetic. Each partial product is the first operand shifted by a bit position, kept only where the second operand has a one. The partial products are combined by exclusive-OR, not by addition, so no carries propagate. The full product is 2*XLEN-1 bits wide. One of three XLEN-bit windows of that product is returned, chosen by a two-bit selector that comes with each operand pair.

The datapath has one XLEN-wide reduction: a balanced binary XOR tree over XLEN masked partial products. For the low window it uses the operands as they arrive. For the reversed and high windows it uses bit-reversed operands and bit-reverses the result. The high window is the reversed window shifted down by one bit.

The operands enter through a valid/ready input stream, and the result leaves through a valid/ready output stream after one register stage.

Back-pressure rules:
- A transfer happens on a rising edge where valid and ready are both high.
- The input is ready whenever the output register is empty or is being drained in the same cycle.
- A held result stays unchanged until the consumer takes it.

Top module: `clmul_unit`

## Requirements
- R1: Selector code 0 returns product bits [XLEN-1:0], where partial products combine by XOR (4'b1101 times 4'b1011 gives 7'b1111111).
- R2: Selector code 1 returns product bits [2*XLEN-2:XLEN-1], the reversed view, which equals the bit reversal of the code-0 result of the bit-reversed operands.
- R3: Selector code 2 returns product bits [2*XLEN-1:XLEN]; its top bit is always 0.
- R4: Selector code 3 returns the same value as code 0.
- R5: A zero operand gives a zero result in every mode, and a second operand of 1 with code 0 returns the first operand.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_result does not change.
- R7: in_ready is high exactly when out_valid is low or out_ready is high. An operand pair accepted on a rising edge shows its result on out_result with out_valid high after that edge.
- R8: After reset out_valid is low, and it stays low in any cycle that follows an edge with no accepted input.
- R9: With out_ready held high, one operand pair is accepted and one result delivered on every cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair and selector are present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | XLEN | First operand (shifted in the partial products) |
| in_b | input | XLEN | Second operand (selects partial products) |
| in_op | input | 2 | View selector: 0 low, 1 reversed, 2 high, 3 low |
| out_valid | output | 1 | out_result holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | XLEN | Selected product window |

## Verification
A new operand pair can be accepted in the same cycle that the previous result is drained, and both actions go through the single output register. The bench provokes this case by streaming every operand pair and selector of a 4-bit instance back to back with out_ready held high. At each falling edge it compares the result of the previous pair against an arithmetic model while it presents the next pair, so a lost, repeated or reordered result shows up as a mismatch. A 32-bit instance repeats the check with directed and random vectors, then holds out_ready low with a second pair waiting, to show that the result stays put and the input is not accepted.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  typedef enum logic [1:0] {
    VIEW_LOW  = 2'd0,
    VIEW_REV  = 2'd1,
    VIEW_HIGH = 2'd2,
    VIEW_ALT  = 2'd3
  } view_e;

  // True for the views that run the tree on bit-reversed operands.
  function automatic logic uses_reversal(input logic [1:0] code);
    return (code == VIEW_REV) || (code == VIEW_HIGH);
  endfunction

endpackage

// File: rtl/clmul_bitrev.sv
module clmul_bitrev #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] flipped;

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped[i] = din[W-1-i];
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/clmul_xor_tree.sv
module clmul_xor_tree #(
  parameter int W = 32
) (
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [W-1:0] prod_lo
);
  // Heap-ordered tree: leaves at indices W..2W-1, root at index 1.
  localparam int NODE_CNT = 2 * W - 1;

  logic [W-1:0] node [1:NODE_CNT];

  for (genvar i = 0; i < W; i++) begin : g_leaf
    assign node[W+i] = mplier[i] ? (mcand << i) : '0;
  end

  for (genvar n = 1; n < W; n++) begin : g_join
    assign node[n] = node[2*n] ^ node[2*n+1];
  end

  assign prod_lo = node[1];
endmodule

// File: rtl/clmul_view_sel.sv
module clmul_view_sel
  import clmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   code,
  input  logic [W-1:0] plain,
  input  logic [W-1:0] unflipped,
  output logic [W-1:0] view
);
  always_comb begin
    unique case (view_e'(code))
      VIEW_REV:  view = unflipped;
      VIEW_HIGH: view = unflipped >> 1;
      default:   view = plain;
    endcase
  end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [1:0]      in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  logic            flip_in;
  logic [XLEN-1:0] a_eff, b_eff, tree_lo, tree_unflip, view;

  assign flip_in = uses_reversal(in_op);

  clmul_bitrev #(.W(XLEN)) u_rev_a (.en(flip_in), .din(in_a), .dout(a_eff));
  clmul_bitrev #(.W(XLEN)) u_rev_b (.en(flip_in), .din(in_b), .dout(b_eff));

  clmul_xor_tree #(.W(XLEN)) u_tree (
    .mcand  (a_eff),
    .mplier (b_eff),
    .prod_lo(tree_lo)
  );

  // The result reversal is always on; the low views take the tree output directly.
  clmul_bitrev #(.W(XLEN)) u_rev_p (.en(1'b1), .din(tree_lo), .dout(tree_unflip));

  clmul_view_sel #(.W(XLEN)) u_sel (
    .code     (in_op),
    .plain    (tree_lo),
    .unflipped(tree_unflip),
    .view     (view)
  );

  // The output stage takes a new pair when it is empty or being drained.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_result <= view;
    end
  end

  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == '0 || in_b == '0)) |-> (tree_lo == '0));

  a_r3_high_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_op == VIEW_HIGH) |-> (view[XLEN-1] == 1'b0));

  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  a_r7_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);
endmodule

// File: tb/clmul_unit_bench.sv
module clmul_unit_bench;
  localparam int SW = 4;
  localparam int BW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic          s_iv, s_ir, s_ov, s_or;
  logic [SW-1:0] s_a, s_b, s_res;
  logic [1:0]    s_op;
  logic          w_iv, w_ir, w_ov, w_or;
  logic [BW-1:0] w_a, w_b, w_res;
  logic [1:0]    w_op;

  clmul_unit #(.XLEN(SW)) u_clmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_a(s_a),
    .in_b(s_b), .in_op(s_op), .out_valid(s_ov), .out_ready(s_or), .out_result(s_res)
  );

  clmul_unit #(.XLEN(BW)) u_clmul_unit_w32 (
    .clk(clk), .rst_n(rst_n), .in_valid(w_iv), .in_ready(w_ir), .in_a(w_a),
    .in_b(w_b), .in_op(w_op), .out_valid(w_ov), .out_ready(w_or), .out_result(w_res)
  );

  // Model: full carry-less product, then the window the selector names.
  function automatic logic [31:0] model(input int w, input logic [31:0] a,
                                        input logic [31:0] b, input logic [1:0] op);
    logic [63:0] p = '0;
    logic [63:0] m;
    for (int i = 0; i < w; i++) if (b[i]) p ^= (64'(a) << i);
    m = (64'd1 << w) - 64'd1;
    case (op)
      2'd1:    return 32'((p >> (w - 1)) & m);
      2'd2:    return 32'((p >> w) & m);
      default: return 32'(p & m);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [1:0] op);
    case (op)
      2'd1: return "R2 reversed view";
      2'd2: return "R3 high view";
      2'd3: return "R4 alternate low code";
      default: return "R1 low view";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_prev;
    logic [31:0] exp_a, exp_b;
    string tag_prev;
    bit pend;
    s_iv = 0; s_or = 1; s_a = '0; s_b = '0; s_op = '0;
    w_iv = 0; w_or = 1; w_a = '0; w_b = '0; w_op = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", 32'(s_ov), 0);
    chk("R7 reset in_ready", 32'(s_ir), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", 32'(w_ov), 0);

    // R9: exhaustive stream over the 4-bit instance, accept and drain every cycle.
    pend = 0; exp_prev = '0; tag_prev = "";
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          if (pend) begin
            chk("R9 stream valid", 32'(s_ov), 1);
            chk(tag_prev, 32'(s_res), exp_prev);
          end
          s_iv = 1; s_a = SW'(a); s_b = SW'(b); s_op = 2'(op);
          exp_prev = model(SW, 32'(a), 32'(b), 2'(op));
          tag_prev = tag(2'(op)); pend = 1;
          @(negedge clk);
        end
    chk(tag_prev, 32'(s_res), exp_prev);
    s_iv = 0;
    @(negedge clk);
    chk("R8 drained", 32'(s_ov), 0);

    // 32-bit directed then random vectors, streamed.
    pend = 0;
    for (int k = 0; k < 260; k++) begin
      logic [31:0] a, b;
      logic [1:0] op;
      if (k < 4)       begin a = 32'hD; b = 32'hB; op = 2'(k); end
      else if (k < 8)  begin a = 32'hDEADBEEF; b = '0; op = 2'(k); end
      else if (k < 12) begin a = '0; b = 32'h12345678; op = 2'(k); end
      else if (k == 12) begin a = 32'hCAFEF00D; b = 32'd1; op = 2'd0; end
      else if (k < 16) begin a = '1; b = '1; op = 2'(k); end
      else begin a = $urandom; b = $urandom; op = 2'($urandom_range(0, 3)); end
      if (pend) chk(tag_prev, w_res, exp_prev);
      w_iv = 1; w_a = a; w_b = b; w_op = op;
      exp_prev = model(BW, a, b, op);
      if (k < 12 || k == 12) tag_prev = "R5 zero or unit operand";
      else tag_prev = tag(op);
      if (k < 4) tag_prev = tag(op);
      pend = 1;
      @(negedge clk);
    end
    chk(tag_prev, w_res, exp_prev);
    w_iv = 0;
    @(negedge clk);
    chk("R1 1101 x 1011", model(BW, 32'hD, 32'hB, 2'd0), 32'h7F);

    // R6 and R7: stall with a second pair waiting.
    w_or = 0; w_iv = 1; w_a = 32'h0F0F1234; w_b = 32'h8000_0003; w_op = 2'd2;
    exp_a = model(BW, w_a, w_b, w_op);
    @(negedge clk);
    w_a = 32'h13579BDF; w_b = 32'h2468ACE0; w_op = 2'd1;
    exp_b = model(BW, w_a, w_b, w_op);
    for (int c = 0; c < 3; c++) begin
      chk("R6 held valid", 32'(w_ov), 1);
      chk("R6 held result", w_res, exp_a);
      chk("R7 stalled ready", 32'(w_ir), 0);
      @(negedge clk);
    end
    w_or = 1;
    #1 chk("R7 ready when draining", 32'(w_ir), 1);
    @(negedge clk);
    chk("R7 next result", w_res, exp_b);
    w_iv = 0;
    @(negedge clk);
    chk("R8 no accept no valid", 32'(w_ov), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule